// File: doc/BRIEF.md
# Static Memory Page-Mode Read Sequencer

This block runs page-mode read cycles on an asynchronous external static memory from a synchronous clock domain. One request reads a whole 16-byte page. The page is fetched as a series of beats. The number of beats depends on the programmed bus width: four beats on a 32-bit bus, eight on a 16-bit bus and sixteen on an 8-bit bus.

Beats are handled in groups of four. The first beat of a group is a long initial access. The other three are short in-page accesses, and during them only the two lowest address bits advance. Between groups the upper address moves on by one word, so the page is read contiguously.

The block drives one of four active-low chip-selects, output enable, four byte-lane strobes and the address. It samples the data bus on the final clock of every beat and returns that value with a one-cycle valid strobe. A done flag marks the last beat of the page. Bus width, both wait counts, the byte-lane policy and the output-enable burst behaviour are captured when a request is accepted.

Top module: `sram_page_reader`

## Requirements
- R1: While reset is asserted, and in idle afterwards, all chip-selects, output enable and byte lanes are high, and beat_valid and page_done are low.
- R2: Width code 0 selects an 8-bit bus and gives 16 beats. Code 1 selects a 16-bit bus and gives 8 beats. Code 2 or 3 selects a 32-bit bus and gives 4 beats.
- R3: A beat with index divisible by four lasts cfg_wait_first+1 clocks. Every other beat lasts cfg_wait_page+1 clocks.
- R4: During beat b, mem_addr[1:0] equals b mod 4 and mem_addr[27:2] equals req_word_addr + floor(b/4).
- R5: The chip-select picked by req_cs is low on every clock of every beat and high otherwise. The other three chip-selects stay high.
- R6: With cfg_lane_en=1, all four lane strobes are low on every beat clock. With 0, they stay high.
- R7: With cfg_oe_burst=0, mem_oe_n is low on every beat clock. With 1, mem_oe_n is high on the first clock of each beat except beat 0 and low on all other beat clocks. Burst mode expects wait fields of at least 1.
- R8: mem_data is sampled on the last clock of each beat. beat_valid is high for exactly the next cycle, with beat_data holding the low 8, 16 or 32 bits for the selected width, zero-extended.
- R9: page_done is high only in the cycle that carries the final beat_valid. In that cycle the block is already idle, with the chip-select released.
- R10: A request, or a change on any configuration input, while a page is in progress has no effect on that page and starts no new page.
- R11: The first beat starts in the cycle after the request is accepted. A request presented during the done cycle is accepted, so pages can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Page read request, accepted when idle |
| req_word_addr | input | 26 | Word address of page start (address bits 27:2) |
| req_cs | input | 2 | Chip-select index |
| cfg_width | input | 2 | Bus width code |
| cfg_wait_first | input | 4 | Initial-access wait field |
| cfg_wait_page | input | 4 | In-page wait field |
| cfg_lane_en | input | 1 | Drive byte lanes low during reads |
| cfg_oe_burst | input | 1 | Toggle output enable between beats |
| mem_data | input | 32 | External data bus |
| mem_addr | output | 28 | External address |
| mem_cs_n | output | 4 | Active-low chip-selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lane_n | output | 4 | Active-low byte-lane strobes |
| beat_valid | output | 1 | Captured beat strobe |
| beat_data | output | 32 | Captured beat data |
| page_done | output | 1 | Final beat of page |

## Verification
All strobes and the address toward the memory change one clock after the request edge. After that they follow the programmed beat lengths clock by clock. A captured beat shows up on beat_valid and beat_data one clock after that beat's last clock, and page_done comes in that same cycle for the final beat. The bench keeps its own beat and clock counters from the accepted request edge, and compares every output at the falling edge of each predicted cycle. Because of that, an extra or a missing wait clock moves every later comparison.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [1:0] {BW_8 = 2'd0, BW_16 = 2'd1, BW_32 = 2'd2} bus_w_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_READ = 1'b1} seq_st_e;

  // log2 of bytes per beat; code 3 behaves as 32-bit
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      BW_8:    width_shift = 2'd0;
      BW_16:   width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pgr_wait_timer.sv
module pgr_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              zero,
  output logic              first
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              first_q, first_d;

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    if (load) begin
      cnt_d   = load_val;
      first_d = 1'b1;
    end else if (run) begin
      first_d = 1'b0;
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign zero  = (cnt_q == '0);
  assign first = first_q;
endmodule

// File: rtl/pgr_addr_step.sv
module pgr_addr_step #(
  parameter int ADDR_W = 28,
  parameter int BEAT_W = 4
) (
  input  logic [ADDR_W-3:0] base_word,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [BEAT_W-1:0] last_idx,
  output logic [ADDR_W-1:0] addr,
  output logic              last_beat,
  output logic              next_is_group_start
);
  logic [ADDR_W-3:0] group_off;

  assign group_off           = (ADDR_W-2)'(beat_idx[BEAT_W-1:2]);
  assign addr                = {base_word + group_off, beat_idx[1:0]};
  assign last_beat           = (beat_idx == last_idx);
  assign next_is_group_start = (beat_idx[1:0] == 2'b11);
endmodule

// File: rtl/pgr_beat_capture.sv
module pgr_beat_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_last,
  input  logic [1:0]        shift,
  input  logic [DATA_W-1:0] bus_data,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic              page_done
);
  localparam logic [DATA_W-1:0] MASK8  = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] MASK16 = DATA_W'(16'hFFFF);

  logic [DATA_W-1:0] masked, data_q;
  logic              valid_q, done_q;

  always_comb begin
    case (shift)
      2'd0:    masked = bus_data & MASK8;
      2'd1:    masked = bus_data & MASK16;
      default: masked = bus_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= cap;
      done_q  <= cap & cap_last;
      if (cap) data_q <= masked;
    end
  end

  assign beat_valid = valid_q;
  assign beat_data  = data_q;
  assign page_done  = done_q;
endmodule

// File: rtl/sram_page_reader.sv
module sram_page_reader #(
  parameter int ADDR_W     = 28,
  parameter int DATA_W     = 32,
  parameter int CS_NUM     = 4,
  parameter int WAIT_W     = 4,
  parameter int PAGE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-3:0]         req_word_addr,
  input  logic [$clog2(CS_NUM)-1:0] req_cs,
  input  logic [1:0]                cfg_width,
  input  logic [WAIT_W-1:0]         cfg_wait_first,
  input  logic [WAIT_W-1:0]         cfg_wait_page,
  input  logic                      cfg_lane_en,
  input  logic                      cfg_oe_burst,
  input  logic [DATA_W-1:0]         mem_data,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [CS_NUM-1:0]         mem_cs_n,
  output logic                      mem_oe_n,
  output logic [DATA_W/8-1:0]       mem_lane_n,
  output logic                      beat_valid,
  output logic [DATA_W-1:0]         beat_data,
  output logic                      page_done
);
  import pgr_pkg::*;

  localparam int CS_W   = $clog2(CS_NUM);
  localparam int LANES  = DATA_W / 8;
  localparam int BEAT_W = $clog2(PAGE_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  seq_st_e           st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-3:0] base_q, base_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic [1:0]        shift_q, shift_d;
  logic [WAIT_W-1:0] wf_q, wf_d, wp_q, wp_d;
  logic              lane_q, lane_d, tog_q, tog_d;

  logic              active, accept, t_zero, t_first, t_load;
  logic [WAIT_W-1:0] t_val;
  logic              last_beat, next_grp;
  logic [BEAT_W-1:0] last_idx;

  assign active   = (st_q == ST_READ);
  assign accept   = (st_q == ST_IDLE) && req_valid;
  assign last_idx = BEAT_W'((PAGE_BYTES >> shift_q) - 1);

  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    base_d  = base_q;
    cs_d    = cs_q;
    shift_d = shift_q;
    wf_d    = wf_q;
    wp_d    = wp_q;
    lane_d  = lane_q;
    tog_d   = tog_q;
    t_load  = 1'b0;
    t_val   = cfg_wait_first;
    if (accept) begin
      st_d    = ST_READ;
      beat_d  = '0;
      base_d  = req_word_addr;
      cs_d    = req_cs;
      shift_d = width_shift(cfg_width);
      wf_d    = cfg_wait_first;
      wp_d    = cfg_wait_page;
      lane_d  = cfg_lane_en;
      tog_d   = cfg_oe_burst;
      t_load  = 1'b1;
    end else if (active && t_zero) begin
      if (last_beat) begin
        st_d = ST_IDLE;
      end else begin
        beat_d = beat_q + 1'b1;
        t_load = 1'b1;
        t_val  = next_grp ? wf_q : wp_q;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      base_q  <= '0;
      cs_q    <= '0;
      shift_q <= 2'd2;
      wf_q    <= '0;
      wp_q    <= '0;
      lane_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      base_q  <= base_d;
      cs_q    <= cs_d;
      shift_q <= shift_d;
      wf_q    <= wf_d;
      wp_q    <= wp_d;
      lane_q  <= lane_d;
      tog_q   <= tog_d;
    end
  end

  pgr_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(srst_n), .load(t_load), .load_val(t_val),
    .run(active), .zero(t_zero), .first(t_first)
  );

  pgr_addr_step #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
    .base_word(base_q), .beat_idx(beat_q), .last_idx(last_idx),
    .addr(mem_addr), .last_beat(last_beat), .next_is_group_start(next_grp)
  );

  pgr_beat_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(srst_n), .cap(active && t_zero), .cap_last(last_beat),
    .shift(shift_q), .bus_data(mem_data), .beat_valid(beat_valid),
    .beat_data(beat_data), .page_done(page_done)
  );

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign mem_cs_n[i] = !(active && (cs_q == CS_W'(i)));
  end

  assign mem_oe_n   = !(active && !(tog_q && t_first && (beat_q != '0)));
  assign mem_lane_n = {LANES{!(active && lane_q)}};
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
  parameter int ADDR_W = 28,
  parameter int CS_NUM = 4,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CS_NUM-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic              beat_valid,
  input logic              page_done
);
  logic sel;
  assign sel = !(&mem_cs_n);

  p_cs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> mem_cs_n == $past(mem_cs_n));

  p_lane_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lane_n == '0) || (&mem_lane_n));

  p_lane_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> &mem_lane_n);

  p_oe_inside_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> sel);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && mem_addr[1:0] != $past(mem_addr[1:0]))
      |-> (2'(mem_addr[1:0] - $past(mem_addr[1:0])) == 2'd1));

  p_done_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> (beat_valid && !sel));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done);
endmodule

bind sram_page_reader pgr_checker #(
  .ADDR_W(ADDR_W), .CS_NUM(CS_NUM), .LANES(DATA_W/8)
) u_pgr_checker (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
  .beat_valid(beat_valid), .page_done(page_done)
);

// File: tb/sram_page_reader_bench.sv
`timescale 1ns/1ps
module sram_page_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [25:0] req_word_addr = '0;
  logic [1:0]  req_cs = '0;
  logic [1:0]  cfg_width = '0;
  logic [3:0]  cfg_wait_first = '0;
  logic [3:0]  cfg_wait_page = '0;
  logic        cfg_lane_en = 1'b0;
  logic        cfg_oe_burst = 1'b0;
  logic [31:0] mem_data;
  logic [27:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n;
  logic [3:0]  mem_lane_n;
  logic        beat_valid;
  logic [31:0] beat_data;
  logic        page_done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  // memory model: data derived from the address presented
  assign mem_data = {mem_addr[7:0] ^ 8'hA5, ~mem_addr[7:0], mem_addr[7:0] ^ 8'h3C, mem_addr[7:0]};

  sram_page_reader u_sram_page_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word_addr(req_word_addr),
    .req_cs(req_cs), .cfg_width(cfg_width), .cfg_wait_first(cfg_wait_first),
    .cfg_wait_page(cfg_wait_page), .cfg_lane_en(cfg_lane_en), .cfg_oe_burst(cfg_oe_burst),
    .mem_data(mem_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .beat_valid(beat_valid), .beat_data(beat_data),
    .page_done(page_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [27:0] a, input int sh);
    logic [31:0] d;
    d = {a[7:0] ^ 8'hA5, ~a[7:0], a[7:0] ^ 8'h3C, a[7:0]};
    if (sh == 0) d = d & 32'h0000_00FF;
    else if (sh == 1) d = d & 32'h0000_FFFF;
    return d;
  endfunction

  task automatic check_idle(input string tag);
    chk(mem_cs_n == 4'hF, tag, mem_cs_n, 4'hF);
    chk(mem_oe_n == 1'b1 && mem_lane_n == 4'hF, tag, {mem_oe_n, mem_lane_n}, 5'h1F);
  endtask

  // bit fields: [41:40] width [39:36] wait_first [35:32] wait_page
  //             [31] lane_en [30] oe_burst [29:28] cs [25:0] word addr
  task automatic run_page(input logic [41:0] v, input bit chain, input bit disturb);
    int sh, nbeats, len;
    logic [27:0] ea;
    logic [31:0] prev_d;
    logic [1:0] w = v[41:40];
    logic [3:0] wf = v[39:36];
    logic [3:0] wp = v[35:32];
    bit lane = v[31];
    bit tog = v[30];
    logic [1:0] cs = v[29:28];
    logic [25:0] wa = v[25:0];
    sh = (w == 2'd0) ? 0 : (w == 2'd1) ? 1 : 2;
    nbeats = 16 >> sh;
    prev_d = '0;
    if (!chain) @(negedge clk);
    cfg_width = w; cfg_wait_first = wf; cfg_wait_page = wp;
    cfg_lane_en = lane; cfg_oe_burst = tog; req_cs = cs; req_word_addr = wa;
    req_valid = 1'b1;
    @(posedge clk);
    for (int b = 0; b < nbeats; b++) begin
      len = ((b % 4) == 0 ? int'(wf) : int'(wp)) + 1;
      ea = {wa + 26'(b / 4), 2'(b % 4)};
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (b == 0 && k == 0) begin
          req_valid = 1'b0;
          if (disturb) begin
            // R10: new request and altered configuration mid-page
            req_valid = 1'b1; cfg_width = ~w; cfg_wait_first = ~wf;
            cfg_wait_page = ~wp; cfg_lane_en = ~lane; cfg_oe_burst = ~tog;
            req_cs = ~cs; req_word_addr = ~wa;
          end
        end
        if (b == nbeats - 1 && k == len - 1) req_valid = 1'b0;
        chk(mem_addr == ea, "R4 address", mem_addr, ea);
        chk(mem_cs_n == ~(4'b0001 << cs), "R5 chip-select", mem_cs_n, ~(4'b0001 << cs));
        chk(mem_lane_n == (lane ? 4'h0 : 4'hF), "R6 lanes", mem_lane_n, lane ? 4'h0 : 4'hF);
        chk(mem_oe_n == (tog && k == 0 && b > 0), "R7 oe", mem_oe_n, (tog && k == 0 && b > 0));
        chk(beat_valid == (k == 0 && b > 0), "R3/R8 beat_valid timing", beat_valid, (k == 0 && b > 0));
        if (k == 0 && b > 0) chk(beat_data == prev_d, "R8 data", beat_data, prev_d);
        chk(page_done == 1'b0, "R9 early done", page_done, 0);
      end
      prev_d = exp_data(ea, sh);
    end
    @(negedge clk);
    chk(beat_valid && page_done, "R9 done with last beat (R2 count)", {beat_valid, page_done}, 2'b11);
    chk(beat_data == prev_d, "R8 last data", beat_data, prev_d);
    check_idle("R9 idle at done");
  endtask

  localparam logic [41:0] VECS [0:5] = '{
    {2'd2, 4'd2, 4'd1, 1'b1, 1'b0, 2'd0, 2'b00, 26'h0000123},
    {2'd1, 4'd2, 4'd1, 1'b0, 1'b1, 2'd1, 2'b00, 26'h0002AF0},
    {2'd0, 4'd3, 4'd1, 1'b1, 1'b1, 2'd2, 2'b00, 26'h3FFFFFC},
    {2'd2, 4'd1, 4'd2, 1'b0, 1'b0, 2'd3, 2'b00, 26'h2000000},
    {2'd3, 4'd4, 4'd3, 1'b1, 1'b1, 2'd0, 2'b00, 26'h0000140},
    {2'd1, 4'd0, 4'd0, 1'b1, 1'b0, 2'd2, 2'b00, 26'h00003FC}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, with a request held during reset
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    chk(!beat_valid && !page_done, "R1 strobes in reset", {beat_valid, page_done}, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");
    chk(!beat_valid && !page_done, "R1 strobes after reset", {beat_valid, page_done}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    foreach (VECS[i]) run_page(VECS[i], 1'b0, 1'b0);

    // R10: mid-page request and config change ignored
    run_page({2'd0, 4'd2, 4'd1, 1'b1, 1'b1, 2'd1, 2'b00, 26'h0000400}, 1'b0, 1'b1);
    @(negedge clk);
    check_idle("R10 no page from ignored request");
    chk(!beat_valid, "R10 no beat after ignored request", beat_valid, 0);

    // R11: request during the done cycle starts a page at once
    run_page({2'd2, 4'd1, 4'd1, 1'b0, 1'b0, 2'd3, 2'b00, 26'h0000800}, 1'b0, 1'b0);
    run_page({2'd1, 4'd1, 4'd1, 1'b1, 1'b0, 2'd0, 2'b00, 26'h0000900}, 1'b1, 1'b0);
    @(negedge clk);
    check_idle("R11 idle after chained page");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule